// File: doc/BRIEF.md
# Strobe-Driven Serial Word Formatter

This block sits beside a dual-slope converter whose result appears as a repeating scan of BCD digits, one digit at a time, with a strobe pulse in the middle of each digit slot during the first scan after a measurement. On every strobe the block captures the digit that is currently selected and its BCD value, and forms an 8-bit word. The upper nibble is a digit tag and the lower nibble is the BCD value. It then sends the word on a UART-style line: one start bit, the eight data bits with the least significant bit first, one parity bit, and one stop bit. A programmable divider sets the bit time.

The sign of the reading does not use a data bit. It is carried in the parity sense. A positive reading sends even parity and a negative reading sends odd parity, so a receiver configured for odd parity reports a parity error for positive readings. The sign is taken when the most significant digit word is loaded and is held for the rest of the burst. In flag mode the three high bits of the most significant digit word, which are always zero for that digit, carry the sign, over-range and under-range.

A strobe that arrives while a word is still shifting is dropped and raises a sticky overrun flag. After the least significant digit word has been sent, the block raises data-ready. The converter's busy signal clears data-ready and overrun when the next measurement starts. A command byte equal to the start code produces a fixed-width high pulse on the run/hold output, which starts a new conversion.

Top module: `strobe_word_serializer`

## Requirements
- R1: While reset is low, on the next clock txd is 1 and tx_active, overrun, data_ready and run_hold are all 0.
- R2: A falling edge of strobe_n that is sampled low at clock edge N loads a word at edge N+1. From that edge txd sends a 0 start bit, then data bits 0 through 7, then the parity bit, then a 1 stop bit. Each bit lasts baud_div+1 clocks.
- R3: digit_sel is one-hot, with bit 4 for the most significant digit down to bit 0 for the least significant digit. The word's bits 7..4 are 0000 for bit 4, 1000 for bit 3, 0100 for bit 2, 1100 for bit 1 and 0010 for bit 0. Bits 3..0 are bcd. If several bits are set, the highest one wins. A strobe with no bit set is ignored.
- R4: When the sign is positive, the nine data-plus-parity bits hold an even number of ones. When the sign is negative, they hold an odd number of ones.
- R5: sign_pos is sampled when the most significant digit word is loaded. The following words use that stored sign, and later changes of sign_pos have no effect on them. The stored sign is positive after reset.
- R6: With flag_mode set, the most significant digit word carries sign_pos in bit 3, over_rng in bit 2, under_rng in bit 1 and bcd bit 0 in bit 0. With flag_mode clear, it carries the plain bcd value.
- R7: A strobe with a digit selected that arrives while tx_active is 1 sets overrun. Its word is dropped and the frame in flight is unchanged.
- R8: data_ready is set on the clock that ends the stop bit of a least significant digit word. A rising edge of busy_in clears both data_ready and overrun, and this clear takes priority over a set in the same clock.
- R9: When cmd_valid is high with cmd_byte equal to 8'h53 and run_hold is low, run_hold goes high on the next edge and stays high for exactly 4 clocks. Other bytes, and commands that arrive while the pulse is running, are ignored.
- R10: tx_active is 1 from the load edge until the stop bit ends. While tx_active is 0, txd is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_div | input | 16 | Bit time minus one, in clocks |
| flag_mode | input | 1 | Pack the status flags into the most significant digit word |
| strobe_n | input | 1 | Active-low strobe from the converter |
| digit_sel | input | 5 | One-hot digit drive; bit 4 is the most significant digit |
| bcd | input | 4 | BCD value of the selected digit |
| sign_pos | input | 1 | 1 for a positive reading |
| over_rng | input | 1 | Over-range status |
| under_rng | input | 1 | Under-range status |
| busy_in | input | 1 | Converter busy; its rising edge clears status |
| cmd_valid | input | 1 | Command byte valid |
| cmd_byte | input | 8 | Received command byte |
| txd | output | 1 | Serial line, idle high |
| tx_active | output | 1 | A frame is being sent |
| overrun | output | 1 | Sticky: a strobe was dropped |
| data_ready | output | 1 | A full burst has been sent |
| run_hold | output | 1 | Conversion start pulse |

## Verification
The bench sends full five-digit bursts with different BCD values, signs and bit times, including a one-clock bit time. Together these separate the tag order, the bit order inside a word and the parity sense. It also flips the sign part-way through a burst, which shows whether the stored sign or the live sign drives the parity. Flag-mode bursts with different over-range and under-range settings show whether the status bits land in the right positions. Closely spaced strobes, a strobe with no digit selected, and both wrong and repeated command bytes show that overrun, ignore and no-retrigger are handled correctly.

// File: rtl/sws_pkg.sv
// Shared constants and helpers for the strobe word serializer.
// Assumes a frame of start + 8 data + parity + stop.
package sws_pkg;
    localparam int FRAME_LEN = 11;
    localparam int BIT_IDX_W = $clog2(FRAME_LEN);

    typedef struct packed {
        logic [3:0] tag;
        logic [3:0] val;
    } sws_word_t;

    // Digit tag: bit-reversed position counted from the most significant digit.
    function automatic logic [3:0] tag_of(input logic [3:0] pos);
        return {pos[0], pos[1], pos[2], pos[3]};
    endfunction
endpackage

// File: rtl/sws_edge.sv
// Edge detector for the strobe and busy inputs.
// Assumes both inputs are synchronous to clk. The strobe passes through two
// flops, so a fall is reported one clock after it is first sampled.
module sws_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    input  logic busy_in,
    output logic strobe_fall,
    output logic busy_rise
);
    logic stb_q1, stb_q2, busy_q;

    // Purpose: delay line for the strobe and last value of busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_q1 <= 1'b1;
            stb_q2 <= 1'b1;
            busy_q <= 1'b0;
        end else begin
            stb_q1 <= strobe_n;
            stb_q2 <= stb_q1;
            busy_q <= busy_in;
        end
    end

    // Purpose: single-cycle event flags.
    always_comb begin
        strobe_fall = stb_q2 & ~stb_q1;
        busy_rise   = busy_in & ~busy_q;
    end
endmodule

// File: rtl/sws_word_build.sv
// Builds the tagged word and the full serial frame from the live digit inputs.
// Assumes digit_sel is one-hot. If several bits are set, the highest wins.
// The sign is taken live for the most significant digit and from held_pos otherwise.
module sws_word_build
    import sws_pkg::*;
#(
    parameter int NDIG     = 5,
    parameter bit FLAGS_EN = 1'b1
) (
    input  logic [NDIG-1:0]      digit_sel,
    input  logic [3:0]           bcd,
    input  logic                 flag_mode,
    input  logic                 sign_pos,
    input  logic                 over_rng,
    input  logic                 under_rng,
    input  logic                 held_pos,
    output logic                 word_valid,
    output logic                 word_msd,
    output logic                 word_lsd,
    output logic [FRAME_LEN-1:0] frame
);
    localparam int SEL_W = (NDIG > 1) ? $clog2(NDIG) : 1;

    logic [SEL_W-1:0] sel_idx;
    logic [3:0]       pos_from_msd;
    logic [3:0]       low_nib;
    logic             use_pos;
    logic             par_bit;
    sws_word_t        word;

    // Purpose: priority-encode the highest selected digit.
    always_comb begin
        sel_idx    = '0;
        word_valid = 1'b0;
        for (int i = 0; i < NDIG; i++) begin
            if (digit_sel[i]) begin
                sel_idx    = SEL_W'(i);
                word_valid = 1'b1;
            end
        end
    end

    // Purpose: classify the selected digit and form its tag.
    always_comb begin
        pos_from_msd = 4'(NDIG - 1) - 4'(sel_idx);
        word_msd     = word_valid && (pos_from_msd == 4'd0);
        word_lsd     = word_valid && (sel_idx == '0);
        word.tag     = tag_of(pos_from_msd);
    end

    // Purpose: choose the lower nibble (plain BCD or packed status flags).
    generate
        if (FLAGS_EN) begin : g_flags
            always_comb begin
                if (word_msd && flag_mode)
                    low_nib = {sign_pos, over_rng, under_rng, bcd[0]};
                else
                    low_nib = bcd;
            end
        end else begin : g_plain
            logic unused_flags;
            always_comb begin
                low_nib      = bcd;
                unused_flags = flag_mode ^ over_rng ^ under_rng;
            end
        end
    endgenerate

    // Purpose: parity in the sense given by the sign, then frame assembly.
    always_comb begin
        word.val = low_nib;
        use_pos  = word_msd ? sign_pos : held_pos;
        par_bit  = use_pos ? (^word) : ~(^word);
        frame    = {1'b1, par_bit, word, 1'b0};
    end
endmodule

// File: rtl/sws_tx_shift.sv
// Shift engine: sends an 11-bit frame LSB first, each bit lasting div+1 clocks.
// Assumes load is only raised while the engine is idle.
module sws_tx_shift
    import sws_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [FRAME_LEN-1:0] frame_in,
    input  logic [DIV_W-1:0]     div,
    output logic                 txd,
    output logic                 active,
    output logic                 last_done
);
    localparam logic [BIT_IDX_W-1:0] LAST_IDX = BIT_IDX_W'(FRAME_LEN - 1);

    logic [FRAME_LEN-1:0] shreg;
    logic [BIT_IDX_W-1:0] bit_idx;
    logic [DIV_W-1:0]     tick;
    logic                 bit_end;

    // Purpose: end-of-bit and end-of-frame detection.
    always_comb begin
        bit_end   = active && (tick == div);
        last_done = bit_end && (bit_idx == LAST_IDX);
    end

    // Purpose: frame load, bit timing and shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg   <= '1;
            bit_idx <= '0;
            tick    <= '0;
            active  <= 1'b0;
        end else if (load) begin
            shreg   <= frame_in;
            bit_idx <= '0;
            tick    <= '0;
            active  <= 1'b1;
        end else if (active) begin
            if (bit_end) begin
                tick <= '0;
                if (bit_idx == LAST_IDX) begin
                    active <= 1'b0;
                    shreg  <= '1;
                end else begin
                    bit_idx <= bit_idx + 1'b1;
                    shreg   <= {1'b1, shreg[FRAME_LEN-1:1]};
                end
            end else begin
                tick <= tick + 1'b1;
            end
        end
    end

    assign txd = shreg[0];
endmodule

// File: rtl/sws_runhold.sv
// Turns a matching command byte into a fixed-width run/hold pulse.
// Assumes PULSE_CYC >= 1. The pulse cannot be retriggered while it is running.
module sws_runhold #(
    parameter int         PULSE_CYC  = 4,
    parameter logic [7:0] START_CODE = 8'h53
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [7:0] cmd_byte,
    output logic       run_hold
);
    localparam int CW = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;

    logic [CW-1:0] remain;

    // Purpose: start, count down and end the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_hold <= 1'b0;
            remain   <= '0;
        end else if (run_hold) begin
            if (remain == '0) run_hold <= 1'b0;
            else              remain   <= remain - 1'b1;
        end else if (cmd_valid && (cmd_byte == START_CODE)) begin
            run_hold <= 1'b1;
            remain   <= CW'(PULSE_CYC - 1);
        end
    end
endmodule

// File: rtl/strobe_word_serializer.sv
// Top level: strobe capture, word build, serial shift, status flags and start pulse.
// Assumes strobes are spaced further apart than one frame time.
module strobe_word_serializer
    import sws_pkg::*;
#(
    parameter int         NDIG       = 5,
    parameter int         DIV_W      = 16,
    parameter bit         FLAGS_EN   = 1'b1,
    parameter int         PULSE_CYC  = 4,
    parameter logic [7:0] START_CODE = 8'h53
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] baud_div,
    input  logic             flag_mode,
    input  logic             strobe_n,
    input  logic [NDIG-1:0]  digit_sel,
    input  logic [3:0]       bcd,
    input  logic             sign_pos,
    input  logic             over_rng,
    input  logic             under_rng,
    input  logic             busy_in,
    input  logic             cmd_valid,
    input  logic [7:0]       cmd_byte,
    output logic             txd,
    output logic             tx_active,
    output logic             overrun,
    output logic             data_ready,
    output logic             run_hold
);
    logic                 strobe_fall, busy_rise;
    logic                 word_valid, word_msd, word_lsd;
    logic [FRAME_LEN-1:0] frame;
    logic                 held_pos, cur_lsd;
    logic                 do_load, do_drop, last_done;

    sws_edge u_edge (
        .clk         (clk),
        .rst_n       (rst_n),
        .strobe_n    (strobe_n),
        .busy_in     (busy_in),
        .strobe_fall (strobe_fall),
        .busy_rise   (busy_rise)
    );

    sws_word_build #(.NDIG(NDIG), .FLAGS_EN(FLAGS_EN)) u_build (
        .digit_sel  (digit_sel),
        .bcd        (bcd),
        .flag_mode  (flag_mode),
        .sign_pos   (sign_pos),
        .over_rng   (over_rng),
        .under_rng  (under_rng),
        .held_pos   (held_pos),
        .word_valid (word_valid),
        .word_msd   (word_msd),
        .word_lsd   (word_lsd),
        .frame      (frame)
    );

    // Purpose: decide between loading and dropping a strobed word.
    always_comb begin
        do_load = strobe_fall && word_valid && !tx_active;
        do_drop = strobe_fall && word_valid &&  tx_active;
    end

    sws_tx_shift #(.DIV_W(DIV_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (do_load),
        .frame_in  (frame),
        .div       (baud_div),
        .txd       (txd),
        .active    (tx_active),
        .last_done (last_done)
    );

    // Purpose: hold the burst sign and remember whether the word in flight is the last digit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_pos <= 1'b1;
            cur_lsd  <= 1'b0;
        end else if (do_load) begin
            cur_lsd <= word_lsd;
            if (word_msd) held_pos <= sign_pos;
        end
    end

    // Purpose: sticky overrun and data-ready flags; busy rise clears them first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun    <= 1'b0;
            data_ready <= 1'b0;
        end else if (busy_rise) begin
            overrun    <= 1'b0;
            data_ready <= 1'b0;
        end else begin
            if (do_drop)              overrun    <= 1'b1;
            if (last_done && cur_lsd) data_ready <= 1'b1;
        end
    end

    sws_runhold #(.PULSE_CYC(PULSE_CYC), .START_CODE(START_CODE)) u_rh (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_byte  (cmd_byte),
        .run_hold  (run_hold)
    );
endmodule

// File: rtl/sws_checker.sv
// Temporal checks on the serializer's ports, attached with bind.
module sws_checker (
    input logic clk,
    input logic rst_n,
    input logic txd,
    input logic tx_active,
    input logic overrun,
    input logic data_ready,
    input logic run_hold,
    input logic cmd_valid
);
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (txd && !tx_active && !overrun && !data_ready && !run_hold));

    assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_active) |-> !txd);

    assert_overrun_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(tx_active));

    assert_ready_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_ready) |-> $fell(tx_active));

    assert_cmd_origin_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_hold) |-> $past(cmd_valid));

    assert_idle_mark_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_active |-> txd);
endmodule

bind strobe_word_serializer sws_checker u_sws_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .txd        (txd),
    .tx_active  (tx_active),
    .overrun    (overrun),
    .data_ready (data_ready),
    .run_hold   (run_hold),
    .cmd_valid  (cmd_valid)
);

// File: tb/test_strobe_word_serializer.sv
module test_strobe_word_serializer;
    localparam int CLK_PERIOD = 10;
    localparam int NDIG  = 5;
    localparam int PULSE = 4;
    localparam logic [7:0] START = 8'h53;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] baud_div = 16'd3;
    logic        flag_mode = 1'b0, strobe_n = 1'b1;
    logic [4:0]  digit_sel = '0;
    logic [3:0]  bcd = '0;
    logic        sign_pos = 1'b1, over_rng = 1'b0, under_rng = 1'b0, busy_in = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_byte = '0;
    logic        txd, tx_active, overrun, data_ready, run_hold;

    int tests = 0, fails = 0, cycles = 0;
    string cur_req = "R2";

    strobe_word_serializer i_strobe_word_serializer (
        .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .flag_mode(flag_mode),
        .strobe_n(strobe_n), .digit_sel(digit_sel), .bcd(bcd), .sign_pos(sign_pos),
        .over_rng(over_rng), .under_rng(under_rng), .busy_in(busy_in),
        .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .txd(txd), .tx_active(tx_active),
        .overrun(overrun), .data_ready(data_ready), .run_hold(run_hold)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference model, advanced on each rising edge
    bit       m_s1 = 1, m_s2 = 1, m_bq = 0, m_act = 0, m_lsd = 0, m_held = 1;
    bit       m_ovr = 0, m_rdy = 0, m_rh = 0;
    int       m_idx = 0, m_tick = 0, m_rhc = 0;
    bit [10:0] m_frame = '1;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 1; m_s2 = 1; m_bq = 0; m_act = 0; m_lsd = 0; m_held = 1;
            m_ovr = 0; m_rdy = 0; m_rh = 0; m_idx = 0; m_tick = 0; m_rhc = 0;
        end else begin
            bit fall, brise, old_act, fin, pos;
            int k;
            bit [3:0] tag, low;
            bit [7:0] w;
            fall = m_s2 && !m_s1;
            brise = busy_in && !m_bq;
            m_s2 = m_s1; m_s1 = strobe_n; m_bq = busy_in;
            k = -1;
            for (int i = 0; i < NDIG; i++) if (digit_sel[i]) k = NDIG - 1 - i;
            old_act = m_act;
            fin = 0;
            if (m_act) begin
                if (m_tick == int'(baud_div)) begin
                    m_tick = 0; m_idx++;
                    if (m_idx == 11) begin m_act = 0; fin = 1; end
                end else m_tick++;
            end
            if (fall && k >= 0) begin
                if (old_act) m_ovr = 1;
                else begin
                    case (k)
                        0: tag = 4'b0000;
                        1: tag = 4'b1000;
                        2: tag = 4'b0100;
                        3: tag = 4'b1100;
                        default: tag = 4'b0010;
                    endcase
                    low = bcd;
                    if (k == 0) begin
                        m_held = sign_pos; pos = sign_pos;
                        if (flag_mode) low = {sign_pos, over_rng, under_rng, bcd[0]};
                    end else pos = m_held;
                    w = {tag, low};
                    m_frame = {1'b1, (pos ? ($countones(w) % 2 == 1) : ($countones(w) % 2 == 0)), w, 1'b0};
                    m_lsd = (k == 4);
                    m_act = 1; m_idx = 0; m_tick = 0;
                end
            end
            if (fin && m_lsd) m_rdy = 1;
            if (brise) begin m_rdy = 0; m_ovr = 0; end
            if (m_rh) begin
                if (m_rhc == 0) m_rh = 0; else m_rhc--;
            end else if (cmd_valid && cmd_byte == START) begin
                m_rh = 1; m_rhc = PULSE - 1;
            end
        end
    end

    task automatic check(string req, string what, logic act, logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare every output to the model on each falling edge
    always @(negedge clk) begin
        cycles++;
        check(cur_req, "txd", txd, m_act ? m_frame[m_idx] : 1'b1);
        check("R10", "tx_active", tx_active, m_act);
        check("R7", "overrun", overrun, m_ovr);
        check("R8", "data_ready", data_ready, m_rdy);
        check("R9", "run_hold", run_hold, m_rh);
    end

    task automatic strobe_digit(int bitpos, logic [3:0] v, int gap);
        digit_sel = 5'(1) << bitpos;
        bcd = v;
        repeat (6) @(negedge clk);
        strobe_n = 1'b0;
        @(negedge clk);
        strobe_n = 1'b1;
        repeat (gap) @(negedge clk);
    endtask

    task automatic burst(logic [3:0] v4, logic [3:0] v3, logic [3:0] v2,
                         logic [3:0] v1, logic [3:0] v0, int gap);
        strobe_digit(4, v4, gap);
        strobe_digit(3, v3, gap);
        strobe_digit(2, v2, gap);
        strobe_digit(1, v1, gap);
        strobe_digit(0, v0, gap);
    endtask

    task automatic busy_pulse();
        busy_in = 1'b1;
        repeat (3) @(negedge clk);
        busy_in = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "txd", txd, 1'b1);
        check("R1", "tx_active", tx_active, 1'b0);
        check("R1", "run_hold", run_hold, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: tag order and BCD nibble, positive sign
        cur_req = "R3";
        burst(4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 56);
        check("R8", "data_ready after burst", data_ready, 1'b1);
        busy_pulse();
        check("R8", "data_ready after busy", data_ready, 1'b0);

        // R4: odd parity for a negative sign, one-clock bit time (R2)
        cur_req = "R4";
        baud_div = 16'd0;
        sign_pos = 1'b0;
        burst(4'd1, 4'd9, 4'd7, 4'd0, 4'd8, 16);
        cur_req = "R2";
        baud_div = 16'd2;
        sign_pos = 1'b1;
        burst(4'd0, 4'd6, 4'd5, 4'd3, 4'd1, 40);
        busy_pulse();

        // R6: flag mode packing; R5: mid-burst sign change ignored
        cur_req = "R6";
        baud_div = 16'd3;
        flag_mode = 1'b1;
        over_rng = 1'b1;
        sign_pos = 1'b1;
        strobe_digit(4, 4'd1, 56);
        cur_req = "R5";
        sign_pos = 1'b0;
        strobe_digit(3, 4'd4, 56);
        strobe_digit(2, 4'd2, 56);
        strobe_digit(1, 4'd9, 56);
        strobe_digit(0, 4'd7, 56);
        cur_req = "R6";
        over_rng = 1'b0;
        under_rng = 1'b1;
        burst(4'd0, 4'd0, 4'd1, 4'd7, 4'd3, 56);
        flag_mode = 1'b0;
        under_rng = 1'b0;
        busy_pulse();

        // R7: strobe during a frame is dropped
        cur_req = "R7";
        sign_pos = 1'b1;
        strobe_digit(4, 4'd1, 8);
        strobe_digit(3, 4'd5, 56);
        check("R7", "overrun after close strobes", overrun, 1'b1);
        busy_pulse();
        check("R7", "overrun after busy", overrun, 1'b0);

        // R3: strobe with no digit selected is ignored; multiple bits pick the highest
        cur_req = "R3";
        digit_sel = '0;
        strobe_n = 1'b0;
        @(negedge clk);
        strobe_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R3", "tx_active after empty strobe", tx_active, 1'b0);
        digit_sel = 5'b00110;
        bcd = 4'd6;
        strobe_n = 1'b0;
        @(negedge clk);
        strobe_n = 1'b1;
        repeat (56) @(negedge clk);

        // R9: command handling
        begin
            int hi;
            hi = 0;
            cmd_valid = 1'b1; cmd_byte = 8'h41;
            @(negedge clk);
            cmd_valid = 1'b0;
            @(negedge clk);
            check("R9", "run_hold after wrong byte", run_hold, 1'b0);
            cmd_valid = 1'b1; cmd_byte = START;
            @(negedge clk); hi += int'(run_hold);
            cmd_valid = 1'b0;
            @(negedge clk); hi += int'(run_hold);
            cmd_valid = 1'b1;
            @(negedge clk); hi += int'(run_hold);
            cmd_valid = 1'b0;
            repeat (20) begin @(negedge clk); hi += int'(run_hold); end
            tests++;
            if (hi != PULSE) begin
                fails++;
                $display("FAIL R9 run_hold width actual=%0d expected=%0d", hi, PULSE);
            end
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule